// File: doc/BRIEF.md
# E1-to-T1 Frame Format Mapper

This block takes a serial stream organised as E1 frames (32 timeslots of 8 bits, 256 bit times per frame) and rebuilds it as T1 frames. Each T1 frame is one framing bit followed by 24 eight-bit channels, 193 bits in all. Every input bit arrives with a bit-enable. The first bit of each E1 frame carries a frame pulse. A 2-bit mode field picks one of three rules that place timeslots into channels.

The output is a gapped stream. An input bit that the active rule keeps appears one clock later with a valid strobe. An input bit that the rule drops produces a clock with the strobe low. The framing bit is marked with a frame-start flag. A later stage uses the strobe to pace the T1 line. Within a timeslot, bit 1 is the first bit received (the MSB) and bit 8 is the last.

Top module: `e1t1_mapper`

## Requirements
- R1: While reset is held, out_vld, out_bit and out_fstart are 0. In mode 00 the held framing bit also starts at 0 after reset.
- R2: Mode 00 (timeslot-gap mapping). Timeslots 1 to 15 pass to channels 1 to 15 and timeslots 17 to 25 pass to channels 16 to 24, in bit order, with out_vld high.
- R3: Mode 00. The framing bit of each output frame is bit 1 of timeslot 26 from the previous input frame. It is sent at the bit time of timeslot 0 bit 8. Until a full input frame has been seen it is 0.
- R4: Mode 00. All other bit times produce out_vld low: timeslot 0 bits 1 to 7, timeslot 16, all of timeslot 26, and timeslots 27 to 31.
- R5: Mode 01 (filler every fourth byte). Timeslot 0 bit 8 is the framing bit. A timeslot whose number is not a multiple of 4 passes. Timeslots 4, 8, ..., 28 and timeslot 0 bits 1 to 7 are dropped.
- R6: Mode 10 (continuous). Timeslot 0 bit 8 is the framing bit. Timeslots 1 to 24 pass to channels 1 to 24. Timeslot 0 bits 1 to 7 and timeslots 25 to 31 are dropped.
- R7: Mode 11 is reserved. It produces no valid output.
- R8: An enabled input bit shows at the outputs on the next clock. A clock with in_en low gives out_vld low on the next clock and does not move the bit position.
- R9: out_fstart is high only together with out_vld, on the framing bit.
- R10: A complete input frame in modes 00, 01 or 10 gives exactly 193 valid output bits.
- R11: mode_sel is sampled only on an enabled bit that carries in_fp. A change at any other time has no effect until the next frame pulse.
- R12: An enabled in_fp at any bit position makes that bit timeslot 0 bit 1. The partial frame in progress is abandoned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_bit | input | 1 | E1 serial data bit |
| in_en | input | 1 | Qualifies in_bit and in_fp |
| in_fp | input | 1 | Marks timeslot 0 bit 1 of an E1 frame |
| mode_sel | input | 2 | 00 timeslot-gap mapping, 01 filler every fourth byte, 10 continuous, 11 reserved |
| out_bit | output | 1 | T1 serial data bit |
| out_vld | output | 1 | out_bit carries a mapped bit |
| out_fstart | output | 1 | out_bit is the T1 framing bit |

## Verification
The hardest case to reach is the mode 00 framing bit. It depends on a bit captured a whole frame earlier. It must read 0 on the first frame after reset and carry the captured value afterwards. The stimulus forces bit 1 of timeslot 26 high in the first frame. It then checks the framing bit of that frame and of the next one.

Two other cases need a hand-built sequence. A second sequence stops a frame partway and sends a frame pulse at an unexpected count. A third changes mode_sel halfway through a frame. Both rely on the bench's own position and mode model staying in step with the block.

// File: rtl/e1t1_pkg.sv
package e1t1_pkg;
  typedef enum logic [1:0] {
    MAP_GAP16  = 2'b00,
    MAP_FILL4  = 2'b01,
    MAP_CONT   = 2'b10,
    MAP_NONE   = 2'b11
  } map_mode_e;

  typedef struct packed {
    logic keep;
    logic is_fbit;
    logic use_held;
    logic capture;
  } map_dec_t;
endpackage

// File: rtl/e1t1_pos_counter.sv
module e1t1_pos_counter #(
  parameter int SLOTS = 32,
  parameter int BITS  = 8,
  localparam int SW = $clog2(SLOTS),
  localparam int BW = $clog2(BITS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_en,
  input  logic          frame_pulse,
  output logic [SW-1:0] cur_slot,
  output logic [BW-1:0] cur_bit
);
  localparam logic [SW-1:0] LAST_SLOT = SW'(SLOTS - 1);
  localparam logic [BW-1:0] LAST_BIT  = BW'(BITS - 1);

  logic [SW-1:0] slot_q, slot_d;
  logic [BW-1:0] bit_q, bit_d;

  always_comb begin
    cur_slot = frame_pulse ? '0 : slot_q;
    cur_bit  = frame_pulse ? '0 : bit_q;
    if (cur_bit == LAST_BIT) begin
      bit_d  = '0;
      slot_d = (cur_slot == LAST_SLOT) ? '0 : cur_slot + 1'b1;
    end else begin
      bit_d  = cur_bit + 1'b1;
      slot_d = cur_slot;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0;
      bit_q  <= '0;
    end else if (bit_en) begin
      slot_q <= slot_d;
      bit_q  <= bit_d;
    end
  end

  // R8
  pos_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> ($stable(slot_q) && $stable(bit_q)));

  // R12
  pos_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && frame_pulse) |=> (slot_q == '0 && bit_q == BW'(1)));
endmodule

// File: rtl/e1t1_slot_map.sv
module e1t1_slot_map
  import e1t1_pkg::*;
#(
  parameter int SLOTS      = 32,
  parameter int BITS       = 8,
  parameter int FILL_GROUP = 4,
  localparam int SW = $clog2(SLOTS),
  localparam int BW = $clog2(BITS)
) (
  input  map_mode_e     mode,
  input  logic [SW-1:0] slot,
  input  logic [BW-1:0] bitn,
  output map_dec_t      dec
);
  localparam logic [SW-1:0] LO_FIRST  = SW'(1);
  localparam logic [SW-1:0] LO_LAST   = SW'(15);
  localparam logic [SW-1:0] HI_FIRST  = SW'(17);
  localparam logic [SW-1:0] HI_LAST   = SW'(25);
  localparam logic [SW-1:0] F_SRC     = SW'(26);
  localparam logic [SW-1:0] CONT_LAST = SW'(24);
  localparam logic [SW-1:0] FG_MASK   = SW'(FILL_GROUP - 1);
  localparam logic [BW-1:0] LAST_BIT  = BW'(BITS - 1);

  logic at_fbit;
  assign at_fbit = (slot == '0) && (bitn == LAST_BIT);

  always_comb begin
    dec = '0;
    unique case (mode)
      MAP_GAP16: begin
        dec.keep     = ((slot >= LO_FIRST) && (slot <= LO_LAST)) ||
                       ((slot >= HI_FIRST) && (slot <= HI_LAST));
        dec.is_fbit  = at_fbit;
        dec.use_held = at_fbit;
        dec.capture  = (slot == F_SRC) && (bitn == '0);
      end
      MAP_FILL4: begin
        dec.keep    = (slot != '0) && ((slot & FG_MASK) != '0);
        dec.is_fbit = at_fbit;
      end
      MAP_CONT: begin
        dec.keep    = (slot >= LO_FIRST) && (slot <= CONT_LAST);
        dec.is_fbit = at_fbit;
      end
      default: dec = '0;
    endcase
  end

  // R9
  fbit_not_kept_chk: assert final (!(dec.keep && dec.is_fbit));
endmodule

// File: rtl/e1t1_f_hold.sv
module e1t1_f_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic cap_en,
  input  logic cap_bit,
  output logic held_bit
);
  logic held_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held_q <= 1'b0;
    else if (cap_en) held_q <= cap_bit;
  end

  assign held_bit = held_q;

  // R3
  held_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |=> $stable(held_q));
endmodule

// File: rtl/e1t1_mapper.sv
module e1t1_mapper
  import e1t1_pkg::*;
#(
  parameter int SLOTS      = 32,
  parameter int BITS       = 8,
  parameter int FILL_GROUP = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_bit,
  input  logic       in_en,
  input  logic       in_fp,
  input  logic [1:0] mode_sel,
  output logic       out_bit,
  output logic       out_vld,
  output logic       out_fstart
);
  localparam int SW = $clog2(SLOTS);
  localparam int BW = $clog2(BITS);

  map_mode_e     mode_q, mode_cur;
  logic [SW-1:0] slot;
  logic [BW-1:0] bitn;
  map_dec_t      dec;
  logic          held_bit;
  logic          bit_d, vld_d, fs_d;
  logic          bit_q, vld_q, fs_q;

  e1t1_pos_counter #(.SLOTS(SLOTS), .BITS(BITS)) pos_i (
    .clk(clk), .rst_n(rst_n), .bit_en(in_en), .frame_pulse(in_fp),
    .cur_slot(slot), .cur_bit(bitn)
  );

  assign mode_cur = in_fp ? map_mode_e'(mode_sel) : mode_q;

  e1t1_slot_map #(.SLOTS(SLOTS), .BITS(BITS), .FILL_GROUP(FILL_GROUP)) map_i (
    .mode(mode_cur), .slot(slot), .bitn(bitn), .dec(dec)
  );

  e1t1_f_hold hold_i (
    .clk(clk), .rst_n(rst_n), .cap_en(in_en && dec.capture),
    .cap_bit(in_bit), .held_bit(held_bit)
  );

  always_comb begin
    vld_d = in_en && (dec.keep || dec.is_fbit);
    fs_d  = in_en && dec.is_fbit;
    bit_d = vld_d ? (dec.use_held ? held_bit : in_bit) : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MAP_GAP16;
      bit_q  <= 1'b0;
      vld_q  <= 1'b0;
      fs_q   <= 1'b0;
    end else begin
      if (in_en) mode_q <= mode_cur;
      bit_q <= bit_d;
      vld_q <= vld_d;
      fs_q  <= fs_d;
    end
  end

  assign out_bit    = bit_q;
  assign out_vld    = vld_q;
  assign out_fstart = fs_q;

  // R9
  fstart_with_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_fstart |-> out_vld);

  // R8
  idle_no_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_en |=> !out_vld);

  // R11
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_en && in_fp) |=> $stable(mode_q));

  // R7
  reserved_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_en && mode_cur == MAP_NONE) |=> !out_vld);
endmodule

// File: tb/e1t1_mapper_tb.sv
module e1t1_mapper_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk, rst_n, in_bit, in_en, in_fp;
  logic [1:0] mode_sel;
  logic out_bit, out_vld, out_fstart;

  int checks, errors, cnt_m, frame_vld;
  logic [1:0] mode_m;
  logic held_m;
  string tag_ovr;
  bit done;

  e1t1_mapper dut_i (
    .clk(clk), .rst_n(rst_n), .in_bit(in_bit), .in_en(in_en), .in_fp(in_fp),
    .mode_sel(mode_sel), .out_bit(out_bit), .out_vld(out_vld),
    .out_fstart(out_fstart)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string req, input logic act, input logic exp,
                       input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic step(input logic b, input logic en, input logic fp,
                      input logic [1:0] sel);
    int pos, s, bt;
    logic [1:0] m;
    logic ev, eb, ef;
    string req;
    @(negedge clk);
    in_bit = b; in_en = en; in_fp = fp; mode_sel = sel;
    ev = 1'b0; eb = 1'b0; ef = 1'b0; req = "R8";
    if (en) begin
      pos = fp ? 0 : cnt_m;
      m   = fp ? sel : mode_m;
      s   = pos / 8;
      bt  = pos % 8;
      ef  = (m != 2'b11) && (s == 0) && (bt == 7);
      case (m)
        2'b00: begin
          ev  = ef || (s >= 1 && s <= 15) || (s >= 17 && s <= 25);
          req = ef ? "R3" : (ev ? "R2" : "R4");
        end
        2'b01: begin ev = ef || (s != 0 && s % 4 != 0); req = "R5"; end
        2'b10: begin ev = ef || (s >= 1 && s <= 24); req = "R6"; end
        default: begin ev = 1'b0; req = "R7"; end
      endcase
      eb = (m == 2'b00 && ef) ? held_m : b;
      if (m == 2'b00 && s == 26 && bt == 0) held_m = b;
      cnt_m  = (pos + 1) % 256;
      mode_m = m;
    end
    if (tag_ovr != "") req = tag_ovr;
    @(posedge clk);
    #1;
    check(req, out_vld, ev, "out_vld");
    if (ev) check(req, out_bit, eb, "out_bit");
    check(ef ? "R9" : req, out_fstart, ef, "out_fstart");
    if (out_vld) frame_vld++;
  endtask

  // Drives nbits enabled bits starting with a frame pulse; sel2 applies from bit 128.
  task automatic send_frame(input logic [1:0] sel, input logic [1:0] sel2,
                            input int nbits, input int gap_pct,
                            input bit force_f);
    frame_vld = 0;
    for (int p = 0; p < nbits; p++) begin
      logic b;
      b = (force_f && p == 208) ? 1'b1 : 1'($urandom);
      while ($urandom % 100 < gap_pct) step(1'($urandom), 1'b0, 1'b0, sel);
      step(b, 1'b1, p == 0, (p < 128) ? sel : sel2);
    end
  endtask

  task automatic frame_count(input logic [1:0] m);
    checks++;
    if (frame_vld != ((m == 2'b11) ? 0 : 193)) begin
      errors++;
      $display("FAIL R10 valid bits per frame actual=%0d expected=%0d",
               frame_vld, (m == 2'b11) ? 0 : 193);
    end
  endtask

  initial begin
    checks = 0; errors = 0; cnt_m = 0; mode_m = 2'b00; held_m = 1'b0;
    tag_ovr = ""; done = 0;
    rst_n = 1'b0; in_bit = 1'b0; in_en = 1'b0; in_fp = 1'b0; mode_sel = 2'b00;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check("R1", out_vld, 1'b0, "out_vld in reset");
    check("R1", out_bit, 1'b0, "out_bit in reset");
    check("R1", out_fstart, 1'b0, "out_fstart in reset");
    @(negedge clk);
    rst_n = 1'b1;

    // R1 R3: first frame framing bit 0, second carries forced TS26 bit
    send_frame(2'b00, 2'b00, 256, 0, 1'b1); frame_count(2'b00);
    send_frame(2'b00, 2'b00, 256, 0, 1'b0); frame_count(2'b00);
    send_frame(2'b00, 2'b00, 256, 30, 1'b0); frame_count(2'b00);
    // R5 R6 R7
    send_frame(2'b01, 2'b01, 256, 0, 1'b0); frame_count(2'b01);
    send_frame(2'b01, 2'b01, 256, 20, 1'b0); frame_count(2'b01);
    send_frame(2'b10, 2'b10, 256, 0, 1'b0); frame_count(2'b10);
    send_frame(2'b10, 2'b10, 256, 25, 1'b0); frame_count(2'b10);
    send_frame(2'b11, 2'b11, 256, 0, 1'b0); frame_count(2'b11);

    // R11: mode_sel changes mid-frame, no effect until next pulse
    tag_ovr = "R11";
    send_frame(2'b10, 2'b01, 256, 0, 1'b0); frame_count(2'b10);
    send_frame(2'b01, 2'b00, 256, 0, 1'b0); frame_count(2'b01);
    send_frame(2'b00, 2'b10, 256, 10, 1'b0); frame_count(2'b00);

    // R12: abandoned partial frames, then an early pulse
    tag_ovr = "R12";
    send_frame(2'b01, 2'b01, 100, 0, 1'b0);
    send_frame(2'b10, 2'b10, 37, 0, 1'b0);
    send_frame(2'b00, 2'b00, 256, 0, 1'b0); frame_count(2'b00);
    tag_ovr = "";
    // R8: idle cycles after traffic
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 1'b0, 2'b00);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule